// File: doc/BRIEF.md
# Dual-Slot Wide Vector Register Datapath

This block holds a private bank of thirty-two 128-bit registers and drives it from two slots that issue in the same cycle. The memory slot moves whole 128-bit words between the bank and a synchronous local data memory. It forms each address by adding a signed 8-bit displacement to a 32-bit base. The arithmetic slot takes two bank registers, combines them by a full-width modular add, a bitwise AND or a bitwise OR, and writes the result to a third register. Either slot may carry a no-operation.

The controls arrive already decoded, one group per slot. Register reads happen in the issue cycle. An arithmetic result lands in the bank at the end of that cycle. Load data lands one cycle later, when the memory returns it. In that return cycle, any read of the register being loaded sees the returning data directly. If both slots would write the same register in the same cycle, the arithmetic result is kept and a one-cycle conflict indication is raised.

Top module: `wvx_dual_slot`

## Requirements
- R1: After reset every register holds zero, `conflict_o` is low and `dmem_we_o` is low while the memory slot is idle.
- R2: For loads and stores, `dmem_addr_o` in the issue cycle equals `mem_base_i` plus `mem_off_i` sign-extended from 8 bits, modulo 2^32 (offsets -128 to +127).
- R3: A store (`mem_op_i` = 2'b10) raises `dmem_we_o` in its issue cycle and drives the register named by `mem_reg_i`, as read in that cycle, onto `dmem_wdata_o`; loads and no-operations keep `dmem_we_o` low.
- R4: A load (`mem_op_i` = 2'b01) writes `dmem_rdata_i`, as presented in the cycle after issue, into the register named by `mem_reg_i` at the end of that cycle.
- R5: `mem_op_i` = 2'b00 and the reserved code 2'b11 perform no memory access: `dmem_we_o` stays low and no register is written.
- R6: `alu_op_i` codes are 2'b01 add (128-bit modular, carries cross every bit, no carry-out), 2'b10 AND, 2'b11 OR; the result of `alu_src_a_i` and `alu_src_b_i` is written to `alu_dst_i` at the end of the issue cycle and is readable from the next cycle.
- R7: `alu_op_i` = 2'b00 writes no register.
- R8: Both slots act in the same cycle independently; a store of a register that the arithmetic slot writes in that same cycle sends the value held before the write.
- R9: In the cycle load data returns, every read of the destination of that load (either arithmetic source or the store source) yields `dmem_rdata_i`.
- R10: When a returning load and an arithmetic operation target the same register in one cycle, the register keeps the arithmetic result and `conflict_o` is high during the following cycle only; otherwise `conflict_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_op_i | input | 2 | Memory slot code: 00 none, 01 load, 10 store, 11 reserved |
| mem_base_i | input | 32 | Base address for the memory slot |
| mem_off_i | input | 8 | Signed displacement added to the base |
| mem_reg_i | input | 5 | Load destination or store source register |
| alu_op_i | input | 2 | Arithmetic slot code: 00 none, 01 add, 10 AND, 11 OR |
| alu_src_a_i | input | 5 | First source register |
| alu_src_b_i | input | 5 | Second source register |
| alu_dst_i | input | 5 | Destination register |
| dmem_addr_o | output | 32 | Local memory address |
| dmem_wdata_o | output | 128 | Local memory write data |
| dmem_we_o | output | 1 | Local memory write enable |
| dmem_rdata_i | input | 128 | Local memory read data, one cycle after the address |
| conflict_o | output | 1 | Pulse marking a same-register write collision |

## Verification
The bench sweeps all 256 displacements against bases near both ends of the address space. A design that zero-extended the offset or truncated the sum would miss the wrapped addresses. Adds of all-ones plus one and of a 32-bit all-ones word plus one catch a datapath split into lanes or one that drops carries. Stores issued in the cycle a load returns, and in the cycle the arithmetic slot writes the same register, catch a missing bypass and a read taken after the write. A load colliding with an arithmetic write checks that the arithmetic value survives and that the flag pulses exactly once; a design with the priority reversed would keep the memory word. The reserved memory code and the arithmetic no-operation are each followed by a store of the register they could have corrupted.

// File: rtl/wds_pkg.sv
package wds_pkg;

    typedef enum logic [1:0] {
        MEM_IDLE  = 2'b00,
        MEM_LOAD  = 2'b01,
        MEM_STORE = 2'b10,
        MEM_RSVD  = 2'b11
    } mem_op_e;

    typedef enum logic [1:0] {
        ALU_IDLE = 2'b00,
        ALU_ADD  = 2'b01,
        ALU_AND  = 2'b10,
        ALU_OR   = 2'b11
    } alu_op_e;

endpackage

// File: rtl/wds_agu.sv
module wds_agu #(
    parameter int AW   = 32,
    parameter int OFFW = 8,
    localparam int EXTW = AW - OFFW
) (
    input  logic [AW-1:0]   base_i,
    input  logic [OFFW-1:0] off_i,
    output logic [AW-1:0]   addr_o
);

    logic [AW-1:0] off_ext;

    always_comb begin
        off_ext = {{EXTW{off_i[OFFW-1]}}, off_i};
        addr_o  = base_i + off_ext;
    end

endmodule

// File: rtl/wds_alu.sv
module wds_alu
    import wds_pkg::*;
#(
    parameter int DW = 128
) (
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic          wr_o,
    output logic [DW-1:0] res_o
);

    always_comb begin
        wr_o  = 1'b1;
        res_o = '0;
        unique case (op_i)
            ALU_ADD:  res_o = a_i + b_i;
            ALU_AND:  res_o = a_i & b_i;
            ALU_OR:   res_o = a_i | b_i;
            ALU_IDLE: wr_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/wds_regfile.sv
module wds_regfile #(
    parameter int NREGS = 32,
    parameter int DW    = 128,
    parameter int NRD   = 3,
    localparam int RIDX = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NRD-1:0][RIDX-1:0]  rd_idx_i,
    output logic [NRD-1:0][DW-1:0]    rd_data_o,
    // port A: arithmetic slot, takes priority
    input  logic                      wa_en_i,
    input  logic [RIDX-1:0]           wa_idx_i,
    input  logic [DW-1:0]             wa_data_i,
    // port B: returning load
    input  logic                      wb_en_i,
    input  logic [RIDX-1:0]           wb_idx_i,
    input  logic [DW-1:0]             wb_data_i
);

    logic [DW-1:0] bank_d [NREGS];
    logic [DW-1:0] bank_q [NREGS];

    always_comb begin
        for (int k = 0; k < NREGS; k++) begin
            bank_d[k] = bank_q[k];
        end
        if (wb_en_i) begin
            bank_d[wb_idx_i] = wb_data_i;
        end
        if (wa_en_i) begin
            bank_d[wa_idx_i] = wa_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREGS; k++) begin
                bank_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < NREGS; k++) begin
                bank_q[k] <= bank_d[k];
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data_o[p] = bank_q[rd_idx_i[p]];
    end

endmodule

// File: rtl/wds_bypass.sv
module wds_bypass #(
    parameter int DW   = 128,
    parameter int RIDX = 5,
    parameter int NRD  = 3
) (
    input  logic [NRD-1:0][RIDX-1:0] idx_i,
    input  logic [NRD-1:0][DW-1:0]   bank_i,
    input  logic                     ret_en_i,
    input  logic [RIDX-1:0]          ret_idx_i,
    input  logic [DW-1:0]            ret_data_i,
    output logic [NRD-1:0][DW-1:0]   data_o
);

    for (genvar p = 0; p < NRD; p++) begin : g_port
        logic hit;
        always_comb begin
            hit       = ret_en_i && (idx_i[p] == ret_idx_i);
            data_o[p] = hit ? ret_data_i : bank_i[p];
        end
    end

endmodule

// File: rtl/wvx_dual_slot.sv
module wvx_dual_slot
    import wds_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int DW    = 128,
    parameter int AW    = 32,
    parameter int OFFW  = 8,
    localparam int RIDX = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mem_op_i,
    input  logic [AW-1:0]   mem_base_i,
    input  logic [OFFW-1:0] mem_off_i,
    input  logic [RIDX-1:0] mem_reg_i,
    input  logic [1:0]      alu_op_i,
    input  logic [RIDX-1:0] alu_src_a_i,
    input  logic [RIDX-1:0] alu_src_b_i,
    input  logic [RIDX-1:0] alu_dst_i,
    output logic [AW-1:0]   dmem_addr_o,
    output logic [DW-1:0]   dmem_wdata_o,
    output logic            dmem_we_o,
    input  logic [DW-1:0]   dmem_rdata_i,
    output logic            conflict_o
);

    localparam int NRD    = 3;
    localparam int RP_A   = 0;
    localparam int RP_B   = 1;
    localparam int RP_STO = 2;

    typedef struct packed {
        logic            ld_pend;
        logic [RIDX-1:0] ld_dst;
        logic            clash;
    } slot_state_t;

    slot_state_t st_d, st_q;

    mem_op_e mop;
    alu_op_e aop;

    logic [NRD-1:0][RIDX-1:0] rd_idx;
    logic [NRD-1:0][DW-1:0]   bank_data;
    logic [NRD-1:0][DW-1:0]   opnd;

    logic          alu_wr;
    logic [DW-1:0] alu_res;

    assign mop = mem_op_e'(mem_op_i);
    assign aop = alu_op_e'(alu_op_i);

    assign rd_idx[RP_A]   = alu_src_a_i;
    assign rd_idx[RP_B]   = alu_src_b_i;
    assign rd_idx[RP_STO] = mem_reg_i;

    wds_regfile #(
        .NREGS (NREGS),
        .DW    (DW),
        .NRD   (NRD)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_i  (rd_idx),
        .rd_data_o (bank_data),
        .wa_en_i   (alu_wr),
        .wa_idx_i  (alu_dst_i),
        .wa_data_i (alu_res),
        .wb_en_i   (st_q.ld_pend),
        .wb_idx_i  (st_q.ld_dst),
        .wb_data_i (dmem_rdata_i)
    );

    wds_bypass #(
        .DW   (DW),
        .RIDX (RIDX),
        .NRD  (NRD)
    ) i_byp (
        .idx_i      (rd_idx),
        .bank_i     (bank_data),
        .ret_en_i   (st_q.ld_pend),
        .ret_idx_i  (st_q.ld_dst),
        .ret_data_i (dmem_rdata_i),
        .data_o     (opnd)
    );

    wds_alu #(
        .DW (DW)
    ) i_alu (
        .op_i  (aop),
        .a_i   (opnd[RP_A]),
        .b_i   (opnd[RP_B]),
        .wr_o  (alu_wr),
        .res_o (alu_res)
    );

    wds_agu #(
        .AW   (AW),
        .OFFW (OFFW)
    ) i_agu (
        .base_i (mem_base_i),
        .off_i  (mem_off_i),
        .addr_o (dmem_addr_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ld_pend = (mop == MEM_LOAD);
        st_d.ld_dst  = mem_reg_i;
        st_d.clash   = st_q.ld_pend && alu_wr && (alu_dst_i == st_q.ld_dst);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dmem_we_o    = (mop == MEM_STORE);
    assign dmem_wdata_o = opnd[RP_STO];
    assign conflict_o   = st_q.clash;

endmodule

// File: rtl/wds_chk.sv
module wds_chk #(
    parameter int DW   = 128,
    parameter int RIDX = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mem_op_i,
    input logic [RIDX-1:0] mem_reg_i,
    input logic [1:0]      alu_op_i,
    input logic [RIDX-1:0] alu_dst_i,
    input logic            dmem_we_o,
    input logic [DW-1:0]   dmem_wdata_o,
    input logic [DW-1:0]   dmem_rdata_i,
    input logic            conflict_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !conflict_o);

    // R5
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_op_i != 2'b10) |-> !dmem_we_o);

    // R9
    store_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we_o && $past(mem_op_i) == 2'b01 && $past(mem_reg_i) == mem_reg_i)
        |-> (dmem_wdata_o == dmem_rdata_i));

    // R10
    clash_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> ($past(mem_op_i, 2) == 2'b01 && $past(alu_op_i) != 2'b00
                        && $past(alu_dst_i) == $past(mem_reg_i, 2)));

    // R10
    clash_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_op_i) == 2'b01 && alu_op_i != 2'b00 && alu_dst_i == $past(mem_reg_i))
        |=> conflict_o);

endmodule

bind wvx_dual_slot wds_chk #(
    .DW   (DW),
    .RIDX (RIDX)
) i_wds_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_op_i     (mem_op_i),
    .mem_reg_i    (mem_reg_i),
    .alu_op_i     (alu_op_i),
    .alu_dst_i    (alu_dst_i),
    .dmem_we_o    (dmem_we_o),
    .dmem_wdata_o (dmem_wdata_o),
    .dmem_rdata_i (dmem_rdata_i),
    .conflict_o   (conflict_o)
);

// File: tb/test_wvx_dual_slot.sv
module test_wvx_dual_slot;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mem_op = 2'b00;
    logic [31:0]  mem_base = '0;
    logic [7:0]   mem_off = '0;
    logic [4:0]   mem_reg = '0;
    logic [1:0]   alu_op = 2'b00;
    logic [4:0]   src_a = '0;
    logic [4:0]   src_b = '0;
    logic [4:0]   dst = '0;
    logic [31:0]  dmem_addr;
    logic [127:0] dmem_wdata;
    logic         dmem_we;
    logic [127:0] dmem_rdata;
    logic         conflict;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [127:0] mem [32];
    logic [127:0] sh [32];
    bit           pend = 1'b0;
    logic [4:0]   pdst = '0;
    logic [127:0] pval = '0;
    bit           exp_conf = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wvx_dual_slot i_wvx_dual_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_op_i     (mem_op),
        .mem_base_i   (mem_base),
        .mem_off_i    (mem_off),
        .mem_reg_i    (mem_reg),
        .alu_op_i     (alu_op),
        .alu_src_a_i  (src_a),
        .alu_src_b_i  (src_b),
        .alu_dst_i    (dst),
        .dmem_addr_o  (dmem_addr),
        .dmem_wdata_o (dmem_wdata),
        .dmem_we_o    (dmem_we),
        .dmem_rdata_i (dmem_rdata),
        .conflict_o   (conflict)
    );

    function automatic logic [127:0] pattern(int k);
        logic [31:0] kk;
        kk = 32'(k);
        if (k == 15) return '1;
        if (k == 14) return 128'd1;
        if (k == 13) return {96'd0, 32'hFFFF_FFFF};
        return {32'h1111_1111 * (kk + 32'd1), ~(32'h0F0F_0F0F + kk),
                32'hDEAD_0000 + kk, kk * 32'h0101_0101};
    endfunction

    // synchronous local memory, read returns the old word
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 32; k++) mem[k] <= pattern(k);
            dmem_rdata <= '0;
        end else begin
            if (dmem_we) mem[dmem_addr[4:0]] <= dmem_wdata;
            dmem_rdata <= mem[dmem_addr[4:0]];
        end
    end

    function automatic logic [127:0] alu_f(logic [1:0] op, logic [127:0] a, logic [127:0] b);
        case (op)
            2'b01:   return a + b;
            2'b10:   return a & b;
            default: return a | b;
        endcase
    endfunction

    function automatic logic [127:0] rd(logic [4:0] i);
        return (pend && i == pdst) ? pval : sh[i];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one issue cycle: drive at negedge, check, update the requirement model
    task automatic cyc(input logic [1:0] mop, input logic [31:0] b, input logic [7:0] o,
                       input logic [4:0] mr, input logic [1:0] aop, input logic [4:0] a,
                       input logic [4:0] bb, input logic [4:0] d, input string tag);
        logic [31:0]  ea;
        logic [127:0] fa, fb, fs;
        bit           nconf;
        mem_op = mop; mem_base = b; mem_off = o; mem_reg = mr;
        alu_op = aop; src_a = a; src_b = bb; dst = d;
        #1;
        ea = b + {{24{o[7]}}, o};
        fa = rd(a); fb = rd(bb); fs = rd(mr);
        if (mop == 2'b10) begin
            chk(dmem_we == 1'b1, "R3 we", 128'(dmem_we), 128'd1);
            chk(dmem_wdata == fs, tag, dmem_wdata, fs);
        end else begin
            chk(dmem_we == 1'b0, (mop == 2'b11) ? "R5 we" : "R3 we", 128'(dmem_we), 128'd0);
        end
        if (mop == 2'b01 || mop == 2'b10)
            chk(dmem_addr == ea, "R2 addr", 128'(dmem_addr), 128'(ea));
        chk(conflict == exp_conf, "R10 conflict", 128'(conflict), 128'(exp_conf));
        nconf = pend && aop != 2'b00 && d == pdst;
        if (pend) sh[pdst] = pval;
        if (aop != 2'b00) sh[d] = alu_f(aop, fa, fb);
        pend = (mop == 2'b01);
        pdst = mr;
        pval = mem[ea[4:0]];
        exp_conf = nconf;
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(2'b00, 32'd0, 8'd0, 5'd0, 2'b00, 5'd0, 5'd0, 5'd0, "R3");
    endtask

    task automatic store(input logic [4:0] r, input string tag);
        cyc(2'b10, 32'd16 + 32'(r[3:0]), 8'd0, r, 2'b00, 5'd0, 5'd0, 5'd0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [4:0] prev;
        for (int k = 0; k < 32; k++) sh[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: quiet outputs right after reset
        chk(conflict == 1'b0, "R1 conflict", 128'(conflict), 128'd0);
        chk(dmem_we == 1'b0, "R1 we", 128'(dmem_we), 128'd0);
        @(negedge clk);
        // R1: every register reads zero
        for (int r = 0; r < 32; r++) store(5'(r), "R1 zero");

        // R2: every displacement with bases near both ends
        for (int o = 0; o < 256; o++)
            cyc(2'b01, (o % 2 == 0) ? 32'h0000_0005 : 32'hFFFF_FFF0, 8'(o), 5'd31,
                2'b00, 5'd0, 5'd0, 5'd0, "R2");
        cyc(2'b01, 32'hFFFF_FFFF, 8'd127, 5'd31, 2'b00, 5'd0, 5'd0, 5'd0, "R2");
        cyc(2'b10, 32'h0000_0000, 8'h80, 5'd0, 2'b00, 5'd0, 5'd0, 5'd0, "R2 st");

        // R4: fill the bank from memory, back-to-back loads
        for (int i = 0; i < 16; i++)
            cyc(2'b01, 32'(i), 8'd0, 5'(i), 2'b00, 5'd0, 5'd0, 5'd0, "R4");
        for (int i = 16; i < 32; i++)
            cyc(2'b01, 32'(31 - i + 100), 8'(-100), 5'(i), 2'b00, 5'd0, 5'd0, 5'd0, "R4");
        idle();
        for (int r = 0; r < 32; r++) store(5'(r), "R4 load data");

        // R5: reserved memory code must not load register 5
        cyc(2'b11, 32'd0, 8'd0, 5'd5, 2'b00, 5'd0, 5'd0, 5'd0, "R5");
        idle();
        store(5'd5, "R5 reg kept");

        // R6: carry across all bits and across a 32-bit boundary
        cyc(2'b00, 32'd0, 8'd0, 5'd0, 2'b01, 5'd15, 5'd14, 5'd20, "R6");
        cyc(2'b00, 32'd0, 8'd0, 5'd0, 2'b01, 5'd13, 5'd14, 5'd21, "R6");
        store(5'd20, "R6 add wrap");
        store(5'd21, "R6 add carry");

        // R6 + R8: sweep of ops, each result stored while the next op issues
        prev = 5'd21;
        for (int d = 0; d < 32; d++) begin
            for (int op = 1; op < 4; op++) begin
                cyc(2'b10, 32'd16 + 32'(prev[3:0]), 8'd0, prev, 2'(op),
                    5'((d + 1) % 32), 5'((d * 5 + 3) % 32), 5'(d), "R6 result");
                prev = 5'(d);
            end
        end
        store(prev, "R6 result");

        // R7: no-operation writes nothing
        cyc(2'b00, 32'd0, 8'd0, 5'd0, 2'b00, 5'd1, 5'd2, 5'd3, "R7");
        store(5'd3, "R7 reg kept");

        // R8: store sees the value before the same-cycle arithmetic write
        cyc(2'b10, 32'd20, 8'd0, 5'd4, 2'b11, 5'd6, 5'd7, 5'd4, "R8 old value");
        store(5'd4, "R8 new value");

        // R9: returning load is bypassed to store and arithmetic sources
        cyc(2'b01, 32'd2, 8'd0, 5'd7, 2'b00, 5'd0, 5'd0, 5'd0, "R9");
        cyc(2'b10, 32'd21, 8'd0, 5'd7, 2'b01, 5'd0, 5'd7, 5'd8, "R9 store bypass");
        store(5'd8, "R9 alu bypass");

        // R10: collision keeps the arithmetic value and pulses the flag once
        cyc(2'b01, 32'd3, 8'd0, 5'd9, 2'b00, 5'd0, 5'd0, 5'd0, "R10");
        cyc(2'b00, 32'd0, 8'd0, 5'd0, 2'b01, 5'd10, 5'd11, 5'd9, "R10");
        store(5'd9, "R10 alu wins");
        idle();
        // R10: different destinations give no flag
        cyc(2'b01, 32'd4, 8'd0, 5'd12, 2'b00, 5'd0, 5'd0, 5'd0, "R10");
        cyc(2'b00, 32'd0, 8'd0, 5'd0, 2'b10, 5'd10, 5'd11, 5'd13, "R10");
        store(5'd12, "R10 load kept");
        store(5'd13, "R10 alu kept");
        idle();

        finish_run();
    end

endmodule